// File: doc/BRIEF.md
# Ternary Column Wildcard Tracker

This block sits beside the write port of a ternary match table that is 64 columns wide. Each ternary bit is stored as two storage bits. The pair `11` means don't-care, and the two complementary pairs stand for the values 0 and 1. On every row write, the block decodes the row to find the columns that hold a don't-care value. It keeps the decoded result of the newest row and of the row before it.

The block also holds a sticky column mask. The mask is the OR of the two history rows and its own fed-back value. After any sequence of writes, a set mask bit means that some row written since the last clear holds a wildcard in that column. Logic that compares successive search keys reads this mask to find the columns it must ignore. The mask only accumulates. Overwriting a wildcard entry with a plain one does not remove its flag. Only a synchronous clear brings the mask back to zero.

Top module: `wildcard_col_tracker`

## Requirements
- R1: After the asynchronous reset `rst_ni` is released, `mask_o` is all zeros.
- R2: Column c is carried in `row_i[2c+1:2c]`. When a write presents `11` in that pair, `mask_o[c]` is 1 after the write. This holds for column 0 and column 63 as well.
- R3: A write whose pair for column c is `01` or `10` does not set `mask_o[c]`.
- R4: A write whose pair for column c is `00` does not set `mask_o[c]`.
- R5: `mask_o` changes on the first rising clock edge at which `wr_en_i` is sampled high. Before that edge, `mask_o` still shows the value it had before the write.
- R6: While `wr_en_i` and `clr_i` are both low, `mask_o` holds its value, whatever `row_i` carries.
- R7: A mask bit that is set stays set through later writes, until a clear.
- R8: When `clr_i` is sampled high, `mask_o` is all zeros after that edge. A write presented in the same cycle is discarded.
- R9: A clear also empties the two-row history. A row without wildcards written after a clear leaves `mask_o` at zero.
- R10: After any sequence of writes, `mask_o` equals the bitwise OR of the wildcard columns of every row written since the last clear or reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Row write strobe from the table update path |
| clr_i | input | 1 | Synchronous clear of the history and the mask; wins over a write |
| row_i | input | 128 | Row being written, two storage bits per column, column c at bits [2c+1:2c] |
| mask_o | output | 64 | Sticky wildcard column mask |

## Verification
Single wildcards at column 0 and column 63 show that the pair-to-column mapping is correct at both ends. Rows made only of complementary pairs, and rows made only of `00`, tell a correct AND decode apart from an OR or XOR decode. Plain rows written after wildcard rows, and after a clear, show whether the mask truly accumulates and whether the history leaks across a clear. A long sequence of random rows, with wildcards sprinkled through it, is compared against a running OR that the bench keeps. Idle cycles with wildcard data on the bus expose any write that ignores the strobe.

// File: rtl/wct_pkg.sv
package wct_pkg;
  localparam int unsigned WCT_COLS_DEF = 64;
  localparam int unsigned WCT_PAIR_W   = 2;
  localparam logic [WCT_PAIR_W-1:0] WCT_PAIR_WILD = 2'b11;
endpackage

// File: rtl/wct_pair_decode.sv
module wct_pair_decode
  import wct_pkg::*;
#(
  parameter int unsigned COLS = WCT_COLS_DEF,
  localparam int unsigned ROW_W = COLS * WCT_PAIR_W
) (
  input  logic [ROW_W-1:0] row_i,
  output logic [COLS-1:0]  wild_o
);
  for (genvar c = 0; c < COLS; c++) begin : g_col
    // both storage bits high marks a don't-care column
    assign wild_o[c] = &row_i[c*WCT_PAIR_W +: WCT_PAIR_W];
  end
endmodule

// File: rtl/wct_row_history.sv
module wct_row_history #(
  parameter int unsigned COLS = wct_pkg::WCT_COLS_DEF
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            wr_en_i,
  input  logic            clr_i,
  input  logic [COLS-1:0] wild_i,
  output logic [COLS-1:0] cur_q_o,
  output logic [COLS-1:0] prev_q_o
);
  logic [COLS-1:0] cur_q, prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cur_q  <= '0;
      prev_q <= '0;
    end else if (clr_i) begin
      cur_q  <= '0;
      prev_q <= '0;
    end else if (wr_en_i) begin
      prev_q <= cur_q;
      cur_q  <= wild_i;
    end
  end

  assign cur_q_o  = cur_q;
  assign prev_q_o = prev_q;

  a_r9_clear_history: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (cur_q == '0) && (prev_q == '0));
  a_r9_shift: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && !clr_i) |=> prev_q == $past(cur_q));
endmodule

// File: rtl/wct_mask_accum.sv
module wct_mask_accum #(
  parameter int unsigned COLS = wct_pkg::WCT_COLS_DEF
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            wr_en_i,
  input  logic            clr_i,
  input  logic [COLS-1:0] wild_i,
  input  logic [COLS-1:0] cur_q_i,
  input  logic [COLS-1:0] prev_q_i,
  output logic [COLS-1:0] mask_o
);
  logic [COLS-1:0] mask_q, mask_d;

  // incoming row and the row becoming previous, ORed with the fed-back mask
  assign mask_d = mask_q | wild_i | cur_q_i | prev_q_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      mask_q <= '0;
    else if (clr_i)   mask_q <= '0;
    else if (wr_en_i) mask_q <= mask_d;
  end

  assign mask_o = mask_q;

  a_r8_clear_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> mask_q == '0);
  a_r7_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clr_i |=> ((mask_q & $past(mask_q)) == $past(mask_q)));
  a_r6_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!wr_en_i && !clr_i) |=> $stable(mask_q));
  a_r2_wild_sets: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && !clr_i) |=> ((mask_q & $past(wild_i)) == $past(wild_i)));
endmodule

// File: rtl/wildcard_col_tracker.sv
module wildcard_col_tracker
  import wct_pkg::*;
#(
  parameter int unsigned COLS = WCT_COLS_DEF,
  localparam int unsigned ROW_W = COLS * WCT_PAIR_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic             clr_i,
  input  logic [ROW_W-1:0] row_i,
  output logic [COLS-1:0]  mask_o
);
  logic [COLS-1:0] wild, cur_q, prev_q;

  wct_pair_decode #(.COLS(COLS)) u_decode (
    .row_i  (row_i),
    .wild_o (wild)
  );

  wct_row_history #(.COLS(COLS)) u_history (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_en_i  (wr_en_i),
    .clr_i    (clr_i),
    .wild_i   (wild),
    .cur_q_o  (cur_q),
    .prev_q_o (prev_q)
  );

  wct_mask_accum #(.COLS(COLS)) u_accum (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_en_i  (wr_en_i),
    .clr_i    (clr_i),
    .wild_i   (wild),
    .cur_q_i  (cur_q),
    .prev_q_i (prev_q),
    .mask_o   (mask_o)
  );

  a_r3_r4_plain_no_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && !clr_i && (wild == '0)) |=> mask_o == $past(mask_o));
endmodule

// File: tb/wildcard_col_tracker_tb.sv
module wildcard_col_tracker_tb;
  localparam int unsigned COLS = 64;
  localparam int unsigned ROW_W = 2 * COLS;
  localparam time CLK_PERIOD = 10ns;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0;
  logic clr = 1'b0;
  logic [ROW_W-1:0] row = '0;
  logic [COLS-1:0] mask;
  logic [COLS-1:0] exp_mask = '0;
  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  wildcard_col_tracker u_dut (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .clr_i(clr),
    .row_i(row), .mask_o(mask)
  );

  // wild bit set -> 11; otherwise val picks 10 (one) or 01 (zero)
  function automatic logic [ROW_W-1:0] mk_row(logic [COLS-1:0] wild, logic [COLS-1:0] val);
    logic [ROW_W-1:0] r;
    for (int c = 0; c < COLS; c++)
      r[2*c +: 2] = wild[c] ? 2'b11 : (val[c] ? 2'b10 : 2'b01);
    return r;
  endfunction

  task automatic check(string req, logic [COLS-1:0] act, logic [COLS-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: mask actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic write_row(logic [ROW_W-1:0] r, logic [COLS-1:0] wild);
    @(negedge clk);
    wr_en = 1'b1; row = r;
    @(negedge clk);
    wr_en = 1'b0;
    exp_mask |= wild;
  endtask

  task automatic t_reset();
    check("R1", mask, '0);
  endtask

  task automatic t_edges();
    logic [COLS-1:0] w = '0;
    w[0] = 1'b1;
    @(negedge clk);
    wr_en = 1'b1; row = mk_row(w, '0);
    #(CLK_PERIOD/4);
    check("R5", mask, exp_mask); // before the edge: unchanged
    @(negedge clk);
    wr_en = 1'b0;
    exp_mask |= w;
    check("R5", mask, exp_mask);
    check("R2", mask & 64'h1, 64'h1);
    w = '0; w[63] = 1'b1;
    write_row(mk_row(w, '1), w);
    check("R2", mask, exp_mask);
  endtask

  task automatic t_plain();
    write_row(mk_row('0, 64'hA5A5_0F0F_3C3C_FFFF), '0);
    check("R3", mask, exp_mask);
    write_row(mk_row('0, '0), '0);
    check("R3", mask, exp_mask);
    write_row('0, '0);
    check("R4", mask, exp_mask);
  endtask

  task automatic t_idle();
    @(negedge clk);
    row = '1;
    repeat (4) @(negedge clk);
    check("R6", mask, exp_mask);
    row = '0;
  endtask

  task automatic t_sticky();
    logic [COLS-1:0] w = 64'h0000_00F0_0000_0100;
    write_row(mk_row(w, '0), w);
    write_row(mk_row('0, '1), '0);
    write_row(mk_row('0, '0), '0);
    check("R7", mask, exp_mask);
    w = 64'h8000_0000_0001_0000;
    write_row(mk_row(w, '0), w);
    check("R10", mask, exp_mask);
  endtask

  task automatic t_clear();
    @(negedge clk);
    clr = 1'b1; wr_en = 1'b1; row = '1;
    @(negedge clk);
    clr = 1'b0; wr_en = 1'b0;
    exp_mask = '0;
    check("R8", mask, exp_mask);
    write_row(mk_row('0, 64'h1234), '0);
    check("R9", mask, exp_mask);
    write_row(mk_row('0, 64'h0), '0);
    check("R9", mask, exp_mask);
  endtask

  task automatic t_random();
    for (int i = 0; i < 60; i++) begin
      logic [COLS-1:0] w = {$urandom, $urandom} & {$urandom, $urandom} & {$urandom, $urandom};
      logic [COLS-1:0] v = {$urandom, $urandom};
      write_row(mk_row(w, v), w);
      if (i % 15 == 14) check("R10", mask, exp_mask);
    end
    check("R10", mask, exp_mask);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_edges();
    t_plain();
    t_idle();
    t_sticky();
    t_clear();
    t_random();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule